// File: doc/BRIEF.md
# Link Activity and Sync Detect Monitor

This block sits next to a video link receiver and decides two things: whether the incoming link clock is alive, and whether the data-enable strobe carried by the link is toggling often enough for the video stream to be trusted. It runs on a free-running reference clock. The link clock is watched by a toggle flop in its own domain. That flop is synchronized into the reference domain, and if no toggle is seen for a set number of reference cycles the link is declared lost. While the link is lost the block raises a low-power request and holds the output-enable low.

When toggles reappear, the low-power request drops at once. The output enable, however, stays low for a set wake-up interval of reference cycles before it rises. The sync-detect flag works separately. It rises once a set number of falling data-enable edges has been counted. It falls when data-enable has shown no edge for a long idle interval, or when the link clock is lost. Either event also restarts the edge count from zero.

An active-low output-off input forces the output enable low at once. It never touches the sync-detect flag. All three time constants are parameters given in reference cycles, so a bench can shrink intervals that are milliseconds long in hardware.

Top module: `la_link_monitor`

## Requirements
- R1: After reset the block drives sync_det = 0, out_en = 0 and lowpwr_req = 1, and out_en stays 0 until the link clock has been seen and the wake interval has run.
- R2: sync_det rises within 4 reference cycles after the FALL_EDGES-th falling edge of link_de (default 40). FALL_EDGES-1 falling edges leave it at 0.
- R3: Once set, sync_det stays 1 while link_de keeps toggling. It falls to 0 when link_de has shown no edge for IDLE_CYC reference cycles, and it does not fall before that interval has elapsed.
- R4: Expiry of the idle interval restarts the falling-edge count at zero. Edges counted before the expiry do not add to those counted after it.
- R5: When link_clk stops toggling for more than LOSS_CYC reference cycles, lowpwr_req goes to 1 and out_en goes to 0. A stop shorter than that does not change either output.
- R6: A declared clock loss forces sync_det to 0 and restarts the falling-edge count at zero.
- R7: After link_clk resumes, lowpwr_req returns to 0 within a few reference cycles. out_en stays 0 for at least WAKE_CYC reference cycles after that and then becomes 1.
- R8: out_off_n = 0 forces out_en to 0 in the same cycle, with no effect on sync_det or lowpwr_req. Returning out_off_n to 1 restores out_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| link_clk | input | 1 | Recovered link pixel clock being monitored |
| link_de | input | 1 | Data-enable strobe from the link |
| out_off_n | input | 1 | Active-low request to disable the data outputs only |
| sync_det | output | 1 | Data-enable activity qualified |
| out_en | output | 1 | Data outputs may be driven |
| lowpwr_req | output | 1 | Link clock lost; request low-power state |

## Verification
A stuck or mis-cleared edge counter shows up at sync_det. It rises one pulse early or late, or it rises after a count that should have been cleared by an idle expiry or a clock loss. The directed scenarios therefore place partial counts on either side of such a clearing event. A fault in the wake-up state machine shows up within a few tens of reference cycles as out_en rising early, or not at all, around the wake interval, or as lowpwr_req failing to follow a stopped clock. Each output is sampled at points on both sides of the nominal threshold so that off-by-a-window errors are visible.

// File: rtl/la_pkg.sv
package la_pkg;
    typedef enum logic [1:0] {
        LNK_LOST   = 2'd0,
        LNK_WAKING = 2'd1,
        LNK_UP     = 2'd2
    } lnk_state_e;
endpackage

// File: rtl/la_clk_watch.sv
module la_clk_watch #(
    parameter int LOSS_CYC = 1000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic link_clk,
    output logic seen,
    output logic lost
);
    localparam int MW = $clog2(LOSS_CYC + 1);
    localparam logic [MW-1:0] MISS_MAX = MW'(LOSS_CYC);

    logic tgl_q;

    always_ff @(posedge link_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    typedef struct packed {
        logic [2:0]    sync;
        logic [MW-1:0] miss;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], tgl_q};
        if (seen)                  st_d.miss = '0;
        else if (st_q.miss != MISS_MAX) st_d.miss = st_q.miss + 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seen = st_q.sync[2] ^ st_q.sync[1];
    assign lost = (st_q.miss == MISS_MAX);

    assert_miss_bound_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        st_q.miss <= MISS_MAX);
    assert_seen_clears_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        seen |=> !lost);
endmodule

// File: rtl/la_wake_fsm.sv
module la_wake_fsm
    import la_pkg::*;
#(
    parameter int WAKE_CYC = 10000
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       seen,
    input  logic       lost,
    output lnk_state_e state
);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

    typedef struct packed {
        lnk_state_e    st;
        logic [WW-1:0] cnt;
    } wake_t;

    wake_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            LNK_LOST: begin
                w_d.cnt = '0;
                if (seen) w_d.st = LNK_WAKING;
            end
            LNK_WAKING: begin
                if (lost) begin
                    w_d.st  = LNK_LOST;
                    w_d.cnt = '0;
                end else if (w_q.cnt == WAKE_LAST) begin
                    w_d.st = LNK_UP;
                end else begin
                    w_d.cnt = w_q.cnt + 1'b1;
                end
            end
            LNK_UP: begin
                if (lost) begin
                    w_d.st  = LNK_LOST;
                    w_d.cnt = '0;
                end
            end
            default: begin
                w_d.st  = LNK_LOST;
                w_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: LNK_LOST, cnt: '0};
        else        w_q <= w_d;
    end

    assign state = w_q.st;

    assert_up_via_wake_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (w_q.st == LNK_UP) |-> ($past(w_q.st) != LNK_LOST));
    assert_lost_leaves_up_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lost && w_q.st != LNK_LOST) |=> (w_q.st == LNK_LOST));
endmodule

// File: rtl/la_sync_qual.sv
module la_sync_qual #(
    parameter int FALL_EDGES = 40,
    parameter int IDLE_CYC   = 16000000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic link_de,
    input  logic clr,
    output logic sync_det
);
    localparam int FW = $clog2(FALL_EDGES + 1);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [FW-1:0] FALL_LAST = FW'(FALL_EDGES - 1);
    localparam logic [FW-1:0] FALL_MAX  = FW'(FALL_EDGES);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

    typedef struct packed {
        logic [2:0]    de_s;
        logic [FW-1:0] falls;
        logic [IW-1:0] idle;
        logic          det;
    } qual_t;

    qual_t q_d, q_q;
    logic  fall_ev, edge_ev, idle_exp;

    assign fall_ev  = q_q.de_s[2] & ~q_q.de_s[1];
    assign edge_ev  = q_q.de_s[2] ^  q_q.de_s[1];
    assign idle_exp = !edge_ev && (q_q.idle == IDLE_LAST);

    always_comb begin
        q_d      = q_q;
        q_d.de_s = {q_q.de_s[1:0], link_de};
        if (edge_ev)       q_d.idle = '0;
        else if (!idle_exp) q_d.idle = q_q.idle + 1'b1;

        if (clr || idle_exp) begin
            q_d.falls = '0;
            q_d.det   = 1'b0;
        end else if (fall_ev) begin
            if (q_q.falls == FALL_LAST) q_d.det = 1'b1;
            if (q_q.falls != FALL_MAX)  q_d.falls = q_q.falls + 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign sync_det = q_q.det;

    assert_fall_bound_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        q_q.falls <= FALL_MAX);
    assert_rise_on_fall_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(q_q.det) |-> $past(fall_ev));
    assert_clr_drops_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        clr |=> (!q_q.det && q_q.falls == '0));
endmodule

// File: rtl/la_link_monitor.sv
module la_link_monitor
    import la_pkg::*;
#(
    parameter int LOSS_CYC   = 1000,
    parameter int WAKE_CYC   = 10000,
    parameter int FALL_EDGES = 40,
    parameter int IDLE_CYC   = 16000000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic link_clk,
    input  logic link_de,
    input  logic out_off_n,
    output logic sync_det,
    output logic out_en,
    output logic lowpwr_req
);
    logic       seen, lost;
    lnk_state_e lstate;

    la_clk_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .link_clk(link_clk),
        .seen    (seen),
        .lost    (lost)
    );

    la_wake_fsm #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .ref_clk(ref_clk),
        .rst_n  (rst_n),
        .seen   (seen),
        .lost   (lost),
        .state  (lstate)
    );

    la_sync_qual #(.FALL_EDGES(FALL_EDGES), .IDLE_CYC(IDLE_CYC)) u_qual (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .link_de (link_de),
        .clr     (lstate == LNK_LOST),
        .sync_det(sync_det)
    );

    assign lowpwr_req = (lstate == LNK_LOST);
    assign out_en     = (lstate == LNK_UP) && out_off_n;

    assert_lowpwr_no_out_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lowpwr_req |-> !out_en);
    assert_off_blocks_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !out_off_n |-> !out_en);
    assert_lowpwr_clears_sync_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        lowpwr_req |=> !sync_det);
endmodule

// File: tb/la_link_monitor_tb.sv
module la_link_monitor_tb;
    localparam int LOSS = 16;
    localparam int WAKE = 64;
    localparam int IDLE = 200;
    localparam int FALLS = 40;

    logic ref_clk = 1'b0;
    logic link_clk = 1'b0;
    logic lclk_run = 1'b1;
    logic rst_n = 1'b0;
    logic link_de = 1'b0;
    logic out_off_n = 1'b1;
    logic sync_det, out_en, lowpwr_req;
    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    always #5 ref_clk = ~ref_clk;
    always begin
        #20;
        if (lclk_run) link_clk = ~link_clk;
    end

    la_link_monitor #(
        .LOSS_CYC(LOSS), .WAKE_CYC(WAKE), .FALL_EDGES(FALLS), .IDLE_CYC(IDLE)
    ) u_dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .link_clk(link_clk), .link_de(link_de),
        .out_off_n(out_off_n), .sync_det(sync_det), .out_en(out_en),
        .lowpwr_req(lowpwr_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic de_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            link_de = 1'b1;
            wait_cyc(8);
            link_de = 1'b0;
            wait_cyc(8);
        end
    endtask

    task automatic test_reset();
        wait_cyc(1);
        chk("R1", "sync_det in reset", sync_det, 1'b0);
        chk("R1", "out_en in reset", out_en, 1'b0);
        chk("R1", "lowpwr_req in reset", lowpwr_req, 1'b1);
        rst_n = 1'b1;
        wait_cyc(30);
        chk("R1", "out_en before wake done", out_en, 1'b0);
        wait_cyc(70);
        chk("R1", "out_en after wake", out_en, 1'b1);
    endtask

    task automatic test_qualify();
        de_pulses(FALLS - 1);
        chk("R2", "sync_det after 39 falls", sync_det, 1'b0);
        de_pulses(1);
        chk("R2", "sync_det after 40 falls", sync_det, 1'b1);
        de_pulses(5);
        chk("R3", "sync_det while toggling", sync_det, 1'b1);
    endtask

    task automatic test_idle();
        wait_cyc(IDLE - 30);
        chk("R3", "sync_det before idle expiry", sync_det, 1'b1);
        wait_cyc(40);
        chk("R3", "sync_det after idle expiry", sync_det, 1'b0);
    endtask

    task automatic test_idle_restart();
        de_pulses(25);
        chk("R4", "sync_det after 25 falls", sync_det, 1'b0);
        wait_cyc(IDLE + 50);
        de_pulses(30);
        chk("R4", "25+30 across idle not enough", sync_det, 1'b0);
        de_pulses(10);
        chk("R4", "40 falls after idle", sync_det, 1'b1);
    endtask

    task automatic test_out_off();
        out_off_n = 1'b0;
        wait_cyc(1);
        chk("R8", "out_en with out_off_n low", out_en, 1'b0);
        chk("R8", "sync_det with out_off_n low", sync_det, 1'b1);
        chk("R8", "lowpwr_req with out_off_n low", lowpwr_req, 1'b0);
        out_off_n = 1'b1;
        wait_cyc(1);
        chk("R8", "out_en restored", out_en, 1'b1);
    endtask

    task automatic test_loss();
        lclk_run = 1'b0;
        wait_cyc(8);
        chk("R5", "lowpwr_req after short stop", lowpwr_req, 1'b0);
        chk("R5", "out_en after short stop", out_en, 1'b1);
        wait_cyc(30);
        chk("R5", "lowpwr_req after loss", lowpwr_req, 1'b1);
        chk("R5", "out_en after loss", out_en, 1'b0);
        chk("R6", "sync_det after loss", sync_det, 1'b0);
    endtask

    task automatic test_wake();
        lclk_run = 1'b1;
        wait_cyc(20);
        chk("R7", "lowpwr_req after clock returns", lowpwr_req, 1'b0);
        chk("R7", "out_en during wake", out_en, 1'b0);
        wait_cyc(40);
        chk("R7", "out_en late in wake", out_en, 1'b0);
        wait_cyc(30);
        chk("R7", "out_en after wake", out_en, 1'b1);
    endtask

    task automatic test_loss_restart();
        de_pulses(25);
        chk("R6", "sync_det after 25 falls", sync_det, 1'b0);
        lclk_run = 1'b0;
        wait_cyc(30);
        chk("R6", "lowpwr_req second loss", lowpwr_req, 1'b1);
        lclk_run = 1'b1;
        wait_cyc(100);
        de_pulses(20);
        chk("R6", "25+20 across loss not enough", sync_det, 1'b0);
        de_pulses(20);
        chk("R6", "40 falls after loss", sync_det, 1'b1);
    endtask

    initial begin
        test_reset();
        test_qualify();
        test_idle();
        test_idle_restart();
        test_out_off();
        test_loss();
        test_wake();
        test_loss_restart();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule